// File: doc/BRIEF.md
# Two-Level Interleaver Address Generator

This block produces the read order for the second constituent encoding of a double-binary turbo code. The frame is a sequence of N bit couples. For each interleaved position j, counted from 0 to N-1, the block emits the natural couple address i to read. With each address it also emits a flag that tells the data path to exchange the two bits of that couple. The mapping works on two levels. The first level exchanges the bits within a couple on even positions. The second level applies a congruential permutation between couples, i = (P0*j + P + 1) mod N, where the offset P depends on j mod 4. No multiplier is used: the term P0*j mod N is kept in an accumulator that adds P0 at each step, and every sum is brought back into [0, N) by conditional subtraction.

A run begins with a single-cycle start pulse, which latches N and the four parameters. Addresses then leave on a valid/ready stream, one per accepted transfer. A last flag marks the final address. Back-pressure rules: while valid is high and ready is low, the address, swap and last outputs hold their values and valid stays high. Position j advances only on a cycle where valid and ready are both high. Valid does not depend on ready. The caller must supply N as a multiple of 4, with each of P0..P3 below N. The permutation and odd/even guarantees additionally require parameters of the usual kind: P0 coprime with N, and offsets that place the four residue classes of j on distinct residues mod 4.

Top module: `ilv_addr_gen`

## Requirements
- R1: A start pulse seen while idle with N >= 4 latches N and P0..P3. out_valid is high from the next cycle, and the first output is address 1 with swap 1.
- R2: The output for position j is (P0*j + P + 1) mod N. P is 0 when j mod 4 = 0, N/2+P1 when j mod 4 = 1, P2 when j mod 4 = 2, and N/2+P3 when j mod 4 = 3.
- R3: Every emitted address lies in [0, N).
- R4: out_swap is 1 for even j and 0 for odd j.
- R5: out_last is 1 only for j = N-1. After that transfer is accepted, out_valid is low in the next cycle.
- R6: While out_valid is high and out_ready is low, out_valid, out_addr, out_swap and out_last hold. Exactly one position is consumed per accepted transfer.
- R7: While a run is active, a start pulse and any change on n_len or p0..p3 have no effect on the emitted sequence.
- R8: A start pulse with n_len below 4 is ignored, so out_valid stays low.
- R9: With conforming parameters, the N addresses of a run form a permutation of 0..N-1. An even j yields an odd address and an odd j yields an even address.
- R10: After reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle pulse that begins a run |
| n_len | input | AW | Frame length N in couples, sampled at start |
| p0 | input | AW | Multiplier step P0, sampled at start |
| p1 | input | AW | Offset parameter for j mod 4 = 1 |
| p2 | input | AW | Offset parameter for j mod 4 = 2 |
| p3 | input | AW | Offset parameter for j mod 4 = 3 |
| out_valid | output | 1 | An address is presented |
| out_ready | input | 1 | Consumer accepts the presented address |
| out_addr | output | AW | Natural couple address i |
| out_swap | output | 1 | Exchange the two bits of this couple |
| out_last | output | 1 | This is position N-1 |

## Verification
The first address is due one clock after the edge that samples start. Each following address is due one clock after the edge on which a transfer is accepted. An ignored start leaves out_valid low at that same one-clock point. The bench drives every input on the falling edge and reads the outputs on the falling edge before the next rising edge, so each read falls exactly where that single register stage has settled. Stall cycles are read one falling edge after ready is pulled low, and are compared with the values captured just before the stall.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} run_st_t;
  localparam int PHASES  = 4;
  localparam int PHASE_W = $clog2(PHASES);
  localparam int MIN_LEN = 4;
endpackage

// File: rtl/ilv_modadd.sv
// Modular sum (a + b + cin) mod n, with a, b < n, using one conditional subtraction.
module ilv_modadd #(
  parameter int AW = 13
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic          cin,
  input  logic [AW-1:0] n,
  output logic [AW-1:0] y
);
  logic [AW:0] sum;
  logic [AW:0] diff;

  always_comb begin
    sum  = {1'b0, a} + {1'b0, b} + {{AW{1'b0}}, cin};
    diff = sum - {1'b0, n};
    y    = (sum >= {1'b0, n}) ? diff[AW-1:0] : sum[AW-1:0];
  end
endmodule

// File: rtl/ilv_offsets.sv
// Per-phase offset table, reduced into [0, N) once when a run is loaded.
module ilv_offsets
  import ilv_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [AW-1:0]              n,
  input  logic [AW-1:0]              p1,
  input  logic [AW-1:0]              p2,
  input  logic [AW-1:0]              p3,
  output logic [PHASES-1:0][AW-1:0]  off_q
);
  logic [AW-1:0]             half_n;
  logic [PHASES-1:0][AW-1:0] off_nx;
  logic [PHASES-1:0][AW-1:0] raw;

  assign half_n = {1'b0, n[AW-1:1]};
  assign raw[0] = '0;
  assign raw[1] = p1;
  assign raw[2] = p2;
  assign raw[3] = p3;

  for (genvar k = 0; k < PHASES; k++) begin : g_phase
    if (k % 2 == 1) begin : g_half
      ilv_modadd #(.AW(AW)) u_red (
        .a(half_n), .b(raw[k]), .cin(1'b0), .n(n), .y(off_nx[k])
      );
    end else begin : g_plain
      assign off_nx[k] = raw[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    off_q <= '0;
    else if (load) off_q <= off_nx;
  end
endmodule

// File: rtl/ilv_accum.sv
// Running value of P0*j mod N, advanced by one step per consumed position.
module ilv_accum #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [AW-1:0] p0,
  input  logic [AW-1:0] n,
  output logic [AW-1:0] acc
);
  logic [AW-1:0] acc_nx;

  ilv_modadd #(.AW(AW)) u_step (
    .a(acc), .b(p0), .cin(1'b0), .n(n), .y(acc_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (step)  acc <= acc_nx;
  end
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
  import ilv_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] n_len,
  input  logic [AW-1:0] p0,
  input  logic [AW-1:0] p1,
  input  logic [AW-1:0] p2,
  input  logic [AW-1:0] p3,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_swap,
  output logic          out_last
);
  run_st_t                   st;
  logic [AW-1:0]             n_q;
  logic [AW-1:0]             p0_q;
  logic [AW-1:0]             j_q;
  logic [AW-1:0]             acc;
  logic [PHASES-1:0][AW-1:0] off_q;
  logic [AW-1:0]             off_sel;
  logic                      load;
  logic                      fire;

  assign load = start && (st == ST_IDLE) && (n_len >= AW'(MIN_LEN));
  assign fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      n_q  <= '0;
      p0_q <= '0;
      j_q  <= '0;
    end else if (load) begin
      st   <= ST_RUN;
      n_q  <= n_len;
      p0_q <= p0;
      j_q  <= '0;
    end else if (fire) begin
      if (out_last) st  <= ST_IDLE;
      else          j_q <= j_q + AW'(1);
    end
  end

  ilv_accum #(.AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(load), .step(fire && !out_last),
    .p0(p0_q), .n(n_q), .acc(acc)
  );

  ilv_offsets #(.AW(AW)) u_off (
    .clk(clk), .rst_n(rst_n), .load(load), .n(n_len),
    .p1(p1), .p2(p2), .p3(p3), .off_q(off_q)
  );

  assign off_sel = off_q[j_q[PHASE_W-1:0]];

  ilv_modadd #(.AW(AW)) u_comb (
    .a(acc), .b(off_sel), .cin(1'b1), .n(n_q), .y(out_addr)
  );

  assign out_valid = (st == ST_RUN);
  assign out_swap  = ~j_q[0];
  assign out_last  = (j_q == n_q - AW'(1));

  // R1: a run opens with address 1 and a swapped couple
  assert_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid && out_addr == AW'(1) && out_swap);

  // R2: accumulator stays reduced during a run
  assert_acc_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> acc < n_q);

  // R3: emitted address below N
  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr < n_q);

  // R4: swap alternates between consecutive positions
  assert_swap_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !out_last |=> out_swap != $past(out_swap));

  // R5: stream closes after the last transfer
  assert_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_last |=> !out_valid);

  // R6: outputs frozen under back-pressure
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr)
      && $stable(out_swap) && $stable(out_last));
endmodule

// File: tb/sim_ilv_addr_gen.sv
module sim_ilv_addr_gen;
  localparam int AW = 13;
  localparam int NV = 5;
  // columns: N, P0, P1, P2, P3, stall, poke
  localparam int VEC [NV][7] = '{
    '{752,  19, 376, 224, 600, 0, 0},
    '{8,     3,   0,   0,   0, 1, 0},
    '{16,    7,  12,  12,  12, 1, 1},
    '{4,     1,   0,   0,   0, 0, 0},
    '{1024, 19, 376, 224, 600, 1, 1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] n_len = '0, p0 = '0, p1 = '0, p2 = '0, p3 = '0;
  logic          out_valid, out_ready, out_swap, out_last;
  logic [AW-1:0] out_addr;
  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  ilv_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .n_len(n_len),
    .p0(p0), .p1(p1), .p2(p2), .p3(p3),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_swap(out_swap), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_addr(int n, int q0, int q1, int q2, int q3, int j);
    longint off;
    case (j % 4)
      0: off = 0;
      1: off = n / 2 + q1;
      2: off = q2;
      default: off = n / 2 + q3;
    endcase
    return int'((longint'(q0) * j + off + 1) % n);
  endfunction

  task automatic run_vec(input int v);
    int n, q0, q1, q2, q3;
    bit stall, poke;
    bit seen [4096];
    int bad_addr, bad_swap, bad_last, bad_rng, bad_hold, bad_par, dup;
    int ea, aa, es, as_, el, al;
    n = VEC[v][0]; q0 = VEC[v][1]; q1 = VEC[v][2]; q2 = VEC[v][3]; q3 = VEC[v][4];
    stall = VEC[v][5] != 0; poke = VEC[v][6] != 0;
    bad_addr = 0; bad_swap = 0; bad_last = 0; bad_rng = 0; bad_hold = 0;
    bad_par = 0; dup = 0; ea = 0; aa = 0; es = 0; as_ = 0; el = 0; al = 0;
    for (int k = 0; k < 4096; k++) seen[k] = 1'b0;
    @(negedge clk);
    n_len = AW'(n); p0 = AW'(q0); p1 = AW'(q1); p2 = AW'(q2); p3 = AW'(q3);
    start = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: first address due one clock after the start edge
    chk(out_valid && out_addr == AW'(1) && out_swap, "R1", int'(out_addr), 1);
    for (int j = 0; j < n; j++) begin
      if (stall && (j % 3 == 1)) begin
        logic [AW-1:0] ha;
        logic hs, hl;
        ha = out_addr; hs = out_swap; hl = out_last;
        out_ready = 1'b0;
        @(negedge clk);
        if (!out_valid || out_addr != ha || out_swap != hs || out_last != hl) bad_hold++;
        out_ready = 1'b1;
      end
      if (poke && j == n / 2) begin
        // R7: start and new parameters during a run
        start = 1'b1; n_len = AW'(8); p0 = AW'(1); p1 = AW'(2); p2 = AW'(2); p3 = AW'(2);
      end
      if (!out_valid || int'(out_addr) != ref_addr(n, q0, q1, q2, q3, j)) begin
        if (bad_addr == 0) begin ea = ref_addr(n, q0, q1, q2, q3, j); aa = int'(out_addr); end
        bad_addr++;
      end
      if (out_swap != (j % 2 == 0)) begin
        if (bad_swap == 0) begin es = (j % 2 == 0); as_ = out_swap; end
        bad_swap++;
      end
      if (out_last != (j == n - 1)) begin
        if (bad_last == 0) begin el = (j == n - 1); al = out_last; end
        bad_last++;
      end
      if (int'(out_addr) >= n) bad_rng++;
      else begin
        if (seen[out_addr]) dup++;
        seen[out_addr] = 1'b1;
      end
      if (out_addr[0] == j[0]) bad_par++;
      @(negedge clk);
      start = 1'b0;
    end
    chk(!out_valid, "R5 valid after last", out_valid, 0);
    chk(bad_addr == 0, poke ? "R2/R7 address" : "R2 address", aa, ea);
    chk(bad_swap == 0, "R4 swap", as_, es);
    chk(bad_last == 0, "R5 last", al, el);
    chk(bad_rng == 0, "R3 range", bad_rng, 0);
    if (stall) chk(bad_hold == 0, "R6 hold", bad_hold, 0);
    chk(dup == 0 && bad_rng == 0, "R9 permutation", dup, 0);
    chk(bad_par == 0, "R9 odd/even", bad_par, 0);
    out_ready = 1'b0;
  endtask

  initial begin
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R10: idle after reset
    chk(!out_valid, "R10 reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R10 after release", out_valid, 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R8: start with N below 4
    @(negedge clk);
    n_len = AW'(2); p0 = AW'(1); start = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!out_valid, "R8 short N", out_valid, 0);
    @(negedge clk);
    chk(!out_valid, "R8 short N later", out_valid, 0);

    // R6: a full stall at the first position keeps it unconsumed
    n_len = AW'(8); p0 = AW'(3); p1 = '0; p2 = '0; p3 = '0; start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(out_valid && out_addr == AW'(1) && out_swap, "R6 stalled first", int'(out_addr), 1);
    out_ready = 1'b1;
    @(negedge clk);
    chk(int'(out_addr) == ref_addr(8, 3, 0, 0, 0, 1) && !out_swap, "R6 one step per transfer",
        int'(out_addr), ref_addr(8, 3, 0, 0, 0, 1));
    repeat (7) @(negedge clk);
    chk(!out_valid, "R5 short run end", out_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule